// File: doc/BRIEF.md
# Strict-Priority and Deficit Round-Robin Egress Scheduler

This block picks which queue of one egress port sends its next packet. It serves one urgent queue and several normal queues. The urgent queue wins at every packet boundary while it holds a packet. When the urgent queue is empty, the normal queues take turns under a deficit round-robin scheme. Each normal queue has a 16-bit weight, and that weight is its byte credit for one turn.

A queue in its turn keeps sending while its signed credit is above zero. It may finish a packet longer than the credit it has left. The excess stays as a negative balance, and the next turn's credit is reduced by it. A queue whose head becomes empty loses any balance, so credit is never banked across idle periods.

The block stores no packets. It reads a valid bit and a 14-bit byte length for the head of each queue. It returns a one-cycle pulse and a one-hot select that names the queue to pop. The source must present the next head before the following clock edge.

Top module: `spdrr_sched`

## Requirements
- R1: While `rstN` is low, `deqPulse` and `deqSel` are zero, whatever the queue inputs show.
- R2: Select encoding: bit 0 of `deqSel` names the urgent queue, and bit k (k = 1..NUM_Q) names normal queue k. `deqSel` has exactly one bit set in a cycle where `deqPulse` is high, and is all zero otherwise. At most one packet is granted per cycle.
- R3: When `prioValid` is high at a clock edge, the next cycle carries a grant to the urgent queue, ahead of every normal queue.
- R4: A grant goes only to a queue whose valid input was high at the edge that produced the grant.
- R5: At the start of a normal queue's turn, its credit is increased by its weight. Weight k sits at bits [16k-1:16(k-1)] of `weights`, and length k sits at bits [14k-1:14(k-1)] of `normLen`. The queue is granted repeatedly while its credit stays above zero and it has a packet. When the credit drops to zero or below, the turn passes on.
- R6: A packet longer than the remaining credit is still granted. The overshoot is carried as a negative credit, and a later turn may then grant nothing to that queue until the weight has paid the debt back.
- R7: A normal queue with no head packet has its credit cleared to zero. A refilled queue therefore starts its next turn with exactly its weight.
- R8: Turns rotate in the fixed order queue 1, 2, 3, then back to 1. Queues with no packet are skipped in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| prioValid | input | 1 | Urgent queue holds a packet |
| normValid | input | NUM_Q | Head valid for each normal queue (bit 0 = queue 1) |
| normLen | input | NUM_Q*LEN_W | Head packet length in bytes, one field per normal queue |
| weights | input | NUM_Q*WT_W | Per-turn byte quantum, one field per normal queue |
| deqSel | output | NUM_Q+1 | One-hot grant: bit 0 urgent, bit k normal queue k |
| deqPulse | output | 1 | A grant is issued this cycle |

## Verification
The hardest state to reach from the ports is a queue that carries debt into a later turn. Reaching it takes a small weight, a long packet and a second backlogged queue, so that the indebted queue's empty turn shows up as a missing grant between the other queue's grants. The clearing of debt on an empty queue needs a two-step stimulus: first leave a queue deep in debt and let it drain, then refill it next to another queue, and check that its first grant comes in its normal turn. Urgent-queue preemption in the middle of a turn is reached by adding an urgent packet from the bench's pop handler right after a chosen grant.

// File: rtl/spdrr_pkg.sv
package spdrr_pkg;
  localparam int unsigned IDX_W = 4;

  typedef struct packed {
    logic             fresh;
    logic             commit;
    logic             send;
    logic [IDX_W-1:0] tgt;
  } dpCtl_t;
endpackage

// File: rtl/spdrr_datapath.sv
module spdrr_datapath
  import spdrr_pkg::*;
#(
  parameter int NUM_Q = 3,
  parameter int LEN_W = 14,
  parameter int WT_W  = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_Q-1:0]       normValid,
  input  logic [NUM_Q*LEN_W-1:0] normLen,
  input  logic [NUM_Q*WT_W-1:0]  weights,
  input  dpCtl_t                 ctl,
  output logic                   dPos,
  output logic                   ndPos
);
  localparam int DEF_W = WT_W + 2;

  logic signed [DEF_W-1:0] defQ [NUM_Q];
  logic signed [DEF_W-1:0] baseVal, dVal, ndVal;
  logic [WT_W-1:0]  wSel;
  logic [LEN_W-1:0] lenSel;

  always_comb begin
    wSel    = '0;
    lenSel  = '0;
    baseVal = '0;
    for (int i = 0; i < NUM_Q; i++) begin
      if (IDX_W'(i) == ctl.tgt) begin
        wSel    = weights[i*WT_W +: WT_W];
        lenSel  = normLen[i*LEN_W +: LEN_W];
        baseVal = defQ[i];
      end
    end
    dVal  = ctl.fresh ? baseVal + $signed({{(DEF_W-WT_W){1'b0}}, wSel}) : baseVal;
    ndVal = dVal - $signed({{(DEF_W-LEN_W){1'b0}}, lenSel});
    dPos  = !dVal[DEF_W-1] && (dVal != '0);
    ndPos = !ndVal[DEF_W-1] && (ndVal != '0);
  end

  for (genvar g = 0; g < NUM_Q; g++) begin : gDef
    always_ff @(posedge clk) begin
      if (!rstN)                                  defQ[g] <= '0;
      else if (!normValid[g])                     defQ[g] <= '0;
      else if (ctl.commit && ctl.tgt == IDX_W'(g)) defQ[g] <= ctl.send ? ndVal : dVal;
    end

    // R7
    empty_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      !normValid[g] |=> (defQ[g] == '0));
  end
endmodule

// File: rtl/spdrr_control.sv
module spdrr_control
  import spdrr_pkg::*;
#(
  parameter int NUM_Q = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             prioValid,
  input  logic [NUM_Q-1:0] normValid,
  input  logic             dPos,
  input  logic             ndPos,
  output dpCtl_t           ctl,
  output logic [NUM_Q:0]   deqSel,
  output logic             deqPulse
);
  localparam int QW = (NUM_Q > 1) ? $clog2(NUM_Q) : 1;

  logic [QW-1:0] curQ, tgtQ, nextQ;
  logic          active;
  logic          anyNorm;

  always_comb begin
    int j;
    tgtQ = curQ;
    for (int k = NUM_Q - 1; k >= 0; k--) begin
      j = int'(curQ) + k;
      if (j >= NUM_Q) j = j - NUM_Q;
      if (normValid[j]) tgtQ = QW'(j);
    end
    nextQ      = (tgtQ == QW'(NUM_Q - 1)) ? '0 : tgtQ + 1'b1;
    anyNorm    = |normValid;
    ctl.tgt    = IDX_W'(tgtQ);
    ctl.fresh  = (tgtQ != curQ) || !active;
    ctl.commit = !prioValid && anyNorm;
    ctl.send   = !prioValid && anyNorm && dPos;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curQ     <= '0;
      active   <= 1'b0;
      deqSel   <= '0;
      deqPulse <= 1'b0;
    end else begin
      deqSel   <= '0;
      deqPulse <= 1'b0;
      if (prioValid) begin
        deqSel   <= (NUM_Q+1)'(1);
        deqPulse <= 1'b1;
      end else if (anyNorm) begin
        if (dPos) begin
          deqSel   <= (NUM_Q+1)'(1) << (int'(tgtQ) + 1);
          deqPulse <= 1'b1;
        end
        if (dPos && ndPos) begin
          curQ   <= tgtQ;
          active <= 1'b1;
        end else begin
          curQ   <= nextQ;
          active <= 1'b0;
        end
      end else begin
        active <= 1'b0;
      end
    end
  end

  // R2
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    deqPulse |-> ($countones(deqSel) == 1));
  // R2
  sel_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !deqPulse |-> (deqSel == '0));
  // R3
  prio_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    prioValid |=> (deqPulse && deqSel[0]));
  // R4
  no_empty_deq_chk: assert property (@(posedge clk) disable iff (!rstN)
    deqPulse |-> ((deqSel[NUM_Q:1] & ~$past(normValid)) == '0));
  // R4
  prio_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    deqSel[0] |-> $past(prioValid));
endmodule

// File: rtl/spdrr_sched.sv
module spdrr_sched
  import spdrr_pkg::*;
#(
  parameter int NUM_Q = 3,
  parameter int LEN_W = 14,
  parameter int WT_W  = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   prioValid,
  input  logic [NUM_Q-1:0]       normValid,
  input  logic [NUM_Q*LEN_W-1:0] normLen,
  input  logic [NUM_Q*WT_W-1:0]  weights,
  output logic [NUM_Q:0]         deqSel,
  output logic                   deqPulse
);
  dpCtl_t ctl;
  logic   dPos, ndPos;

  spdrr_control #(.NUM_Q(NUM_Q)) u_ctrl (
    .clk(clk), .rstN(rstN), .prioValid(prioValid), .normValid(normValid),
    .dPos(dPos), .ndPos(ndPos), .ctl(ctl), .deqSel(deqSel), .deqPulse(deqPulse)
  );

  spdrr_datapath #(.NUM_Q(NUM_Q), .LEN_W(LEN_W), .WT_W(WT_W)) u_dp (
    .clk(clk), .rstN(rstN), .normValid(normValid), .normLen(normLen),
    .weights(weights), .ctl(ctl), .dPos(dPos), .ndPos(ndPos)
  );
endmodule

// File: tb/spdrr_sched_tb.sv
`timescale 1ns/1ps
module spdrr_sched_tb;
  localparam int NQ = 3, LW = 14, WW = 16;

  logic clk = 1'b0, rstN = 1'b0;
  logic prioValid;
  logic [NQ-1:0] normValid;
  logic [NQ*LW-1:0] normLen;
  logic [NQ*WW-1:0] weights;
  logic [NQ:0] deqSel;
  logic deqPulse;

  int pkt[NQ+1][$];
  int expQ[$];
  int total = 0, bad = 0, pulses = 0, injectAt = -1, injectLen = 0;
  bit done = 0;

  always #10 clk = ~clk;

  spdrr_sched #(.NUM_Q(NQ), .LEN_W(LW), .WT_W(WW)) u_dut (
    .clk(clk), .rstN(rstN), .prioValid(prioValid), .normValid(normValid),
    .normLen(normLen), .weights(weights), .deqSel(deqSel), .deqPulse(deqPulse)
  );

  task automatic drive();
    prioValid = pkt[0].size() > 0;
    for (int k = 0; k < NQ; k++) begin
      normValid[k] = pkt[k+1].size() > 0;
      normLen[k*LW +: LW] = normValid[k] ? LW'(pkt[k+1][0]) : '0;
    end
  endtask

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(int id, int len);
    expQ.push_back(id * 65536 + len);
  endtask

  task automatic setW(int a, int b, int c);
    weights = {WW'(c), WW'(b), WW'(a)};
  endtask

  task automatic finishUp();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // monitor: pops the scoreboard on each grant and pops the granted queue
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && deqPulse) begin
        int id, act, exp;
        id = -1;
        if ($countones(deqSel) != 1)
          check(0, "R2 one-hot grant", $countones(deqSel), 1);
        else
          for (int k = 0; k <= NQ; k++) if (deqSel[k]) id = k;
        if (id >= 0) begin
          act = id * 65536 + (pkt[id].size() > 0 ? pkt[id][0] : 65535);
          check(pkt[id].size() > 0, "R4 grant to empty queue", id, -1);
          if (expQ.size() == 0) check(0, "R3 R5 R8 unexpected grant", act, -1);
          else begin
            exp = expQ.pop_front();
            check(act == exp, "R3 R5 R6 R8 grant order (id*65536+len)", act, exp);
          end
          if (pkt[id].size() > 0) void'(pkt[id].pop_front());
          pulses++;
          if (pulses == injectAt) pkt[0].push_back(injectLen);
          drive();
        end
      end
    end
  end

  task automatic waitDrain(string req);
    int cnt;
    bit busy;
    cnt = 0;
    busy = 1;
    while (busy && cnt < 8000) begin
      @(negedge clk);
      cnt++;
      busy = expQ.size() > 0;
      for (int k = 0; k <= NQ; k++) if (pkt[k].size() > 0) busy = 1;
    end
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, {req, " missing grants"}, expQ.size(), 0);
    check(!busy, {req, " queues drained"}, busy, 0);
  endtask

  // reference model of the requirements for the long mixed run
  task automatic modelRun(int startQ);
    int mq[NQ][$];
    int d[NQ];
    int cur, tgt, j, dd, nd, ln;
    bit act, any, fresh;
    cur = startQ;
    act = 0;
    for (int k = 0; k < NQ; k++) begin mq[k] = pkt[k+1]; d[k] = 0; end
    foreach (pkt[0][i]) push(0, pkt[0][i]);
    forever begin
      any = 0;
      for (int k = 0; k < NQ; k++) if (mq[k].size() == 0) d[k] = 0; else any = 1;
      if (!any) break;
      tgt = -1;
      for (int k = NQ - 1; k >= 0; k--) begin
        j = (cur + k) % NQ;
        if (mq[j].size() > 0) tgt = j;
      end
      fresh = (tgt != cur) || !act;
      dd = fresh ? d[tgt] + int'(weights[tgt*WW +: WW]) : d[tgt];
      if (dd > 0) begin
        ln = mq[tgt].pop_front();
        push(tgt + 1, ln);
        nd = dd - ln;
        d[tgt] = nd;
        if (nd > 0) begin cur = tgt; act = 1; end
        else begin cur = (tgt + 1) % NQ; act = 0; end
      end else begin
        d[tgt] = dd;
        cur = (tgt + 1) % NQ;
        act = 0;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      check(0, "watchdog expired", 0, 1);
      finishUp();
    end
  end

  initial begin
    setW(0, 0, 0);
    pkt[0].push_back(64);
    pkt[1].push_back(64);
    drive();
    repeat (3) @(negedge clk);
    check(deqPulse == 1'b0, "R1 pulse low in reset", deqPulse, 0);
    check(deqSel == '0, "R1 select zero in reset", deqSel, 0);
    pkt[0].delete();
    pkt[1].delete();
    drive();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(deqPulse == 1'b0, "R1 idle after reset", deqPulse, 0);

    // R6: overshoot carried, debt repaid over later turns
    setW(500, 2000, 2000);
    pkt[1] = '{1500, 1500};
    pkt[2] = '{1000, 1000, 1000, 1000};
    push(1, 1500); push(2, 1000); push(2, 1000);
    push(2, 1000); push(2, 1000); push(1, 1500);
    drive();
    waitDrain("R6 overshoot");

    // R3: urgent queue first, and again when it appears mid-turn
    setW(3000, 3000, 3000);
    injectAt = pulses + 2;
    injectLen = 77;
    pkt[0] = '{100};
    pkt[1] = '{1000, 1000};
    pkt[2] = '{1000};
    push(0, 100); push(2, 1000); push(0, 77); push(1, 1000); push(1, 1000);
    drive();
    waitDrain("R3 preemption");
    injectAt = -1;

    // R5 R8: fixed rotation, empty queue 2 skipped
    setW(100, 100, 100);
    pkt[1] = '{64, 64, 64};
    pkt[3] = '{64, 64};
    push(1, 64); push(1, 64); push(3, 64); push(3, 64); push(1, 64);
    drive();
    waitDrain("R5 R8 rotation");

    // R7: deep debt on queue 3, drain it, refill: debt must be gone
    pkt[3] = '{1000};
    push(3, 1000);
    drive();
    waitDrain("R7 debt build");
    pkt[1] = '{100, 100};
    pkt[3] = '{100};
    push(1, 100); push(3, 100); push(1, 100);
    drive();
    waitDrain("R7 empty clears credit");

    // mixed long run against the model; turn pointer now rests on queue 2
    setW($urandom_range(3000, 50), $urandom_range(3000, 50), $urandom_range(3000, 50));
    for (int i = 0; i < 3; i++) pkt[0].push_back($urandom_range(1518, 64));
    for (int k = 1; k <= NQ; k++)
      for (int i = 0; i < 12; i++) pkt[k].push_back($urandom_range(1518, 64));
    modelRun(1);
    drive();
    waitDrain("R5 R6 R8 mixed run");

    done = 1;
    finishUp();
  end
endmodule